// File: doc/BRIEF.md
# Bit-Time Timestamp and Transmit Event Logger

This block provides the time reference for a CAN controller. A 16-bit counter advances by one for every (prescale+1) bit-time ticks that the protocol engine supplies, and wraps freely. The host side may instead select an externally generated 16-bit time vector as the timestamp source. The internal counter keeps running while the external vector is selected.

Two start-of-frame strobes, one for reception and one for transmission, latch the current timestamp into separate capture registers. When a transmission completes, the block writes a two-word event record into a circular event queue. The record holds the frame identifier, its extended-format flag and the transmit timestamp. The host reads the oldest record from the output words and releases it with an acknowledge pulse. When the queue is full, a new event is discarded and a sticky loss flag is raised; the host clears that flag.

Top module: `ts_event_logger`

## Requirements
- R1: After reset, ts_o (with the internal source selected) is 0, rx_ts_o and tx_ts_o are 0, ev_level_o is 0, ev_empty_o is 1, ev_full_o is 0 and ev_lost_o is 0.
- R2: The internal counter increments by exactly 1 on every (presc_i+1)-th cycle that has tick_i high, one clock after that tick. It does not change in a cycle without tick_i.
- R3: The internal counter wraps from 0xFFFF to 0x0000 on the next qualifying tick.
- R4: While ext_sel_i is 1, ts_o equals ext_ts_i in the same cycle. Ticks received meanwhile still advance the internal counter, and that counter is visible on ts_o again once ext_sel_i returns to 0.
- R5: A cycle with rx_sof_i high loads rx_ts_o with that cycle's ts_o, visible from the next clock. rx_ts_o holds its value otherwise.
- R6: A cycle with tx_sof_i high loads tx_ts_o the same way. tx_ts_o holds otherwise, and it is independent of rx_sof_i.
- R7: A tx_done_i pulse enqueues one record. ev_word0_o carries tx_id_i in bits 28:0, tx_xtd_i in bit 30, and zero in bits 29 and 31. ev_word1_o carries the tx_ts_o value of that cycle in bits 15:0, with the upper half zero. Records leave in arrival order.
- R8: ev_level_o counts the stored records (0..DEPTH). ev_empty_o is high at level 0 and ev_full_o is high at level DEPTH. Both output words read zero while the queue is empty.
- R9: ev_ack_i removes the oldest record when the queue is not empty. On an empty queue it has no effect.
- R10: A tx_done_i arriving while the queue is full, with no ack in the same cycle, is dropped. Level and stored records are unchanged, and ev_lost_o becomes 1 and stays 1.
- R11: When the queue is full and tx_done_i and ev_ack_i coincide, the oldest record is removed and the new one is stored. The level stays DEPTH and ev_lost_o is not set.
- R12: lost_clr_i clears ev_lost_o. When a drop happens in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One pulse per CAN bit time |
| presc_i | input | PRESC_W (4) | Tick divider minus one |
| ext_sel_i | input | 1 | Select the external time vector |
| ext_ts_i | input | 16 | External time vector |
| ts_o | output | 16 | Current timestamp |
| rx_sof_i | input | 1 | Receive start-of-frame strobe |
| rx_ts_o | output | 16 | Captured receive timestamp |
| tx_sof_i | input | 1 | Transmit start-of-frame strobe |
| tx_ts_o | output | 16 | Captured transmit timestamp |
| tx_done_i | input | 1 | Transmit complete, enqueue an event |
| tx_id_i | input | 29 | Identifier of the completed frame |
| tx_xtd_i | input | 1 | Completed frame used an extended identifier |
| ev_ack_i | input | 1 | Host releases the oldest record |
| lost_clr_i | input | 1 | Host clears the loss flag |
| ev_word0_o | output | 32 | Oldest record, identifier word |
| ev_word1_o | output | 32 | Oldest record, timestamp word |
| ev_level_o | output | clog2(DEPTH+1) (4) | Stored record count |
| ev_empty_o | output | 1 | Queue empty |
| ev_full_o | output | 1 | Queue full |
| ev_lost_o | output | 1 | Sticky: an event was dropped |

## Verification
Two queue operations can fall in the same cycle: a transmit-complete push and a host acknowledge. This matters most at the full boundary. There, a push that lines up with an acknowledge must be accepted without raising the loss flag, while an unpaired push must be dropped. The bench fills the queue to DEPTH and then drives tx_done_i and ev_ack_i in the same clock. It judges the result from the level, the loss flag and the next head record. A second collision, a drop in the same cycle as lost_clr_i, is provoked and judged by the flag remaining set.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int TS_W = 16;
  localparam int ID_W = 29;

  typedef struct packed {
    logic            xtd;
    logic [ID_W-1:0] id;
    logic [TS_W-1:0] ts;
  } ev_rec_t;

  function automatic logic [31:0] rec_word0(ev_rec_t r);
    return {1'b0, r.xtd, 1'b0, r.id};
  endfunction

  function automatic logic [31:0] rec_word1(ev_rec_t r);
    return {{(32-TS_W){1'b0}}, r.ts};
  endfunction
endpackage

// File: rtl/ts_timebase.sv
module ts_timebase
  import ts_pkg::*;
#(
  parameter int PRESC_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic               ext_sel_i,
  input  logic [TS_W-1:0]    ext_ts_i,
  output logic [TS_W-1:0]    ts_o
);
  logic [PRESC_W-1:0] pcnt_q;
  logic [TS_W-1:0]    cnt_q;
  logic               adv;

  assign adv = tick_i && (pcnt_q >= presc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      cnt_q  <= '0;
    end else if (tick_i) begin
      if (adv) begin
        pcnt_q <= '0;
        cnt_q  <= cnt_q + 1'b1;  // free wrap
      end else begin
        pcnt_q <= pcnt_q + 1'b1;
      end
    end
  end

  assign ts_o = ext_sel_i ? ext_ts_i : cnt_q;

  p_hold_no_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  p_step_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> cnt_q == TS_W'($past(cnt_q) + 1'b1));
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && cnt_q == {TS_W{1'b1}}) |=> cnt_q == '0);
endmodule

// File: rtl/ts_capture.sv
module ts_capture
  import ts_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sof_i,
  input  logic [TS_W-1:0] ts_i,
  output logic [TS_W-1:0] cap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cap_o <= '0;
    else if (sof_i) cap_o <= ts_i;
  end

  p_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> cap_o == $past(ts_i));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i |=> $stable(cap_o));
endmodule

// File: rtl/ts_event_fifo.sv
module ts_event_fifo
  import ts_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    push_i,
  input  ev_rec_t rec_i,
  input  logic    pop_i,
  input  logic    lost_clr_i,
  output ev_rec_t head_o,
  output logic [LW-1:0] level_o,
  output logic    empty_o,
  output logic    full_o,
  output logic    lost_o
);
  ev_rec_t         mem_q [DEPTH];
  logic [AW-1:0]   wr_q, rd_q;
  logic [LW-1:0]   lvl_q;
  logic            lost_q;
  logic            do_pop, do_push, drop;

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (lvl_q == '0);
  assign full_o  = (lvl_q == LW'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);
  assign drop    = push_i && full_o && !do_pop;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= rec_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      lvl_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
      if (drop)            lost_q <= 1'b1;  // set wins over clear
      else if (lost_clr_i) lost_q <= 1'b0;
    end
  end

  assign head_o  = empty_o ? '0 : mem_q[rd_q];
  assign level_o = lvl_q;
  assign lost_o  = lost_q;

  p_level_bounded_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= LW'(DEPTH));
  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (full_o && lost_o && $stable(rd_q)));
  p_pop_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> empty_o);
  p_swap_full_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && pop_i && !lost_o && !lost_clr_i) |=> (full_o && !lost_o));
  p_lost_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lost_o && !lost_clr_i) |=> lost_o);
endmodule

// File: rtl/ts_event_logger.sv
module ts_event_logger
  import ts_pkg::*;
#(
  parameter int PRESC_W = 4,
  parameter int DEPTH   = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic               ext_sel_i,
  input  logic [15:0]        ext_ts_i,
  output logic [15:0]        ts_o,
  input  logic               rx_sof_i,
  output logic [15:0]        rx_ts_o,
  input  logic               tx_sof_i,
  output logic [15:0]        tx_ts_o,
  input  logic               tx_done_i,
  input  logic [28:0]        tx_id_i,
  input  logic               tx_xtd_i,
  input  logic               ev_ack_i,
  input  logic               lost_clr_i,
  output logic [31:0]        ev_word0_o,
  output logic [31:0]        ev_word1_o,
  output logic [LW-1:0]      ev_level_o,
  output logic               ev_empty_o,
  output logic               ev_full_o,
  output logic               ev_lost_o
);
  ev_rec_t new_rec, head;

  ts_timebase #(.PRESC_W(PRESC_W)) u_tb (
    .clk_i, .rst_ni, .tick_i, .presc_i, .ext_sel_i, .ext_ts_i, .ts_o
  );

  ts_capture u_rx_cap (
    .clk_i, .rst_ni, .sof_i(rx_sof_i), .ts_i(ts_o), .cap_o(rx_ts_o)
  );

  ts_capture u_tx_cap (
    .clk_i, .rst_ni, .sof_i(tx_sof_i), .ts_i(ts_o), .cap_o(tx_ts_o)
  );

  assign new_rec = '{xtd: tx_xtd_i, id: tx_id_i, ts: tx_ts_o};

  ts_event_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_done_i), .rec_i(new_rec), .pop_i(ev_ack_i), .lost_clr_i,
    .head_o(head), .level_o(ev_level_o), .empty_o(ev_empty_o),
    .full_o(ev_full_o), .lost_o(ev_lost_o)
  );

  assign ev_word0_o = rec_word0(head);
  assign ev_word1_o = rec_word1(head);

  p_empty_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_empty_o |-> (ev_word0_o == '0 && ev_word1_o == '0));
  p_push_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && !ev_ack_i && !ev_full_o) |=> ev_level_o == $past(ev_level_o) + 1'b1);
endmodule

// File: tb/ts_event_logger_test.sv
module ts_event_logger_test;
  localparam int DEPTH = 8;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic tick = 0, ext_sel = 0, rx_sof = 0, tx_sof = 0, tx_done = 0, tx_xtd = 0;
  logic ack = 0, lost_clr = 0;
  logic [3:0] presc = 0;
  logic [15:0] ext_ts = 0;
  logic [28:0] tx_id = 0;
  logic [15:0] ts, rx_ts, tx_ts;
  logic [31:0] w0, w1;
  logic [LW-1:0] level;
  logic empty, full, lost;
  int checks = 0, errors = 0;

  ts_event_logger #(.PRESC_W(4), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .presc_i(presc),
    .ext_sel_i(ext_sel), .ext_ts_i(ext_ts), .ts_o(ts),
    .rx_sof_i(rx_sof), .rx_ts_o(rx_ts), .tx_sof_i(tx_sof), .tx_ts_o(tx_ts),
    .tx_done_i(tx_done), .tx_id_i(tx_id), .tx_xtd_i(tx_xtd),
    .ev_ack_i(ack), .lost_clr_i(lost_clr),
    .ev_word0_o(w0), .ev_word1_o(w1), .ev_level_o(level),
    .ev_empty_o(empty), .ev_full_o(full), .ev_lost_o(lost)
  );

  always #4 clk = ~clk;

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; #3; step(); rst_n = 1; step();
  endtask

  function automatic logic [31:0] wd0(logic x, logic [28:0] id);
    return {1'b0, x, 1'b0, id};
  endfunction

  task automatic push_ev(logic [15:0] t, logic [28:0] id, logic x);
    ext_sel = 1; ext_ts = t; tx_sof = 1; step(); tx_sof = 0;
    tx_done = 1; tx_id = id; tx_xtd = x; step(); tx_done = 0;
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 ts", ts, 0); chk("R1 rx_ts", rx_ts, 0); chk("R1 tx_ts", tx_ts, 0);
    chk("R1 level", level, 0); chk("R1 empty", empty, 1);
    chk("R1 full", full, 0); chk("R1 lost", lost, 0);

    // R2: exhaustive tick counts per prescale value, with idle gaps
    for (int p = 0; p < 4; p++) begin
      do_reset(); presc = 4'(p);
      for (int n = 1; n <= 3 * (p + 1) + 1; n++) begin
        tick = 1; step(); tick = 0;
        chk("R2 tick", ts, 32'(n / (p + 1)));
        step();
        chk("R2 idle", ts, 32'(n / (p + 1)));
      end
    end

    // R3: full wrap
    do_reset(); presc = 0; tick = 1;
    repeat (65535) step();
    chk("R3 top", ts, 16'hFFFF);
    step(); tick = 0;
    chk("R3 wrap", ts, 0);

    // R4: external source, internal keeps counting
    ext_sel = 1;
    foreach (ext_ts[i]) begin
      ext_ts = 16'h1 << i; #1;
      chk("R4 ext", ts, 32'(16'h1 << i));
    end
    ext_ts = 16'hA5A5; tick = 1; repeat (5) step(); tick = 0;
    chk("R4 ext hold", ts, 16'hA5A5);
    ext_sel = 0; #1;
    chk("R4 internal", ts, 5);

    // R5/R6: capture
    ext_sel = 1; ext_ts = 16'h3C3C; rx_sof = 1; step(); rx_sof = 0;
    chk("R5 cap", rx_ts, 16'h3C3C); chk("R6 indep", tx_ts, 0);
    ext_ts = 16'h1111; step();
    chk("R5 hold", rx_ts, 16'h3C3C);
    tx_sof = 1; step(); tx_sof = 0;
    chk("R6 cap", tx_ts, 16'h1111); chk("R5 indep", rx_ts, 16'h3C3C);
    ext_ts = 16'h2222; step();
    chk("R6 hold", tx_ts, 16'h1111);

    // R7/R8: fill
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      push_ev(16'h1000 + 16'(i), 29'h1000000 + 29'(i * 3), i[0]);
      chk("R8 level", level, 32'(i + 1));
      chk("R8 empty", empty, 0);
      chk("R8 full", full, (i == DEPTH - 1) ? 1 : 0);
    end
    chk("R7 head w0", w0, wd0(1'b0, 29'h1000000));
    chk("R7 head w1", w1, 32'h1000);

    // R10: drop when full
    push_ev(16'hBEEF, 29'h0ABCDEF, 1'b1);
    chk("R10 lost", lost, 1); chk("R10 level", level, DEPTH);
    chk("R10 head", w0, wd0(1'b0, 29'h1000000));

    // R11: push and ack together at full (tx_ts is BEEF)
    lost_clr = 1; step(); lost_clr = 0;
    chk("R12 clear", lost, 0);
    tx_done = 1; tx_id = 29'h15; tx_xtd = 1; ack = 1; step(); tx_done = 0; ack = 0;
    chk("R11 level", level, DEPTH); chk("R11 lost", lost, 0);
    chk("R11 head", w0, wd0(1'b1, 29'h1000003));

    // R12: drop and clear in the same cycle, set wins
    tx_done = 1; tx_id = 29'h77; lost_clr = 1; step(); tx_done = 0; lost_clr = 0;
    chk("R12 set wins", lost, 1); chk("R10 level", level, DEPTH);
    lost_clr = 1; step(); lost_clr = 0;
    chk("R12 clear", lost, 0);

    // R7/R9: drain in order
    for (int i = 1; i < DEPTH; i++) begin
      chk("R7 order w0", w0, wd0(i[0], 29'h1000000 + 29'(i * 3)));
      chk("R7 order w1", w1, 32'h1000 + 32'(i));
      ack = 1; step(); ack = 0;
      chk("R9 level", level, 32'(DEPTH - i));
    end
    chk("R7 swap w0", w0, wd0(1'b1, 29'h15));
    chk("R7 swap w1", w1, 32'hBEEF);
    ack = 1; step(); ack = 0;
    chk("R8 empty", empty, 1); chk("R8 zero w0", w0, 0); chk("R8 zero w1", w1, 0);

    // R9: ack on empty
    ack = 1; step(); step(); ack = 0;
    chk("R9 empty ack level", level, 0); chk("R9 empty ack flag", empty, 1);
    chk("R9 empty ack full", full, 0);
    push_ev(16'h4321, 29'h1FFFFFFF, 1'b1);
    chk("R9 after w0", w0, wd0(1'b1, 29'h1FFFFFFF));
    chk("R9 after w1", w1, 32'h4321);
    chk("R9 after level", level, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule